// File: doc/BRIEF.md
# Master/Frame Clock Alignment Watchdog

This block sits beside the framing logic of a serial digital audio transmitter. The master clock runs it. It takes a bit clock and a frame (sample-rate) clock, both sampled as levels that are synchronous to the master clock. A two-bit ratio select gives the number of master-clock cycles in one frame period: 128 times one more than the select value.

The block comes out of power-down and counts a fixed number of bit-clock rising edges before it reports itself ready. The first frame-clock rising edge after that becomes the reference. From then on, each interval between frame rising edges is measured in master-clock cycles. The interval is compared with the period that the ratio select expects. If the interval differs from that period by three times 128 cycles or more, the block emits a single-cycle reset to the transmitter's frame and bit counters. The same happens if no frame edge arrives before the late limit.

A slip reset leaves the ready flag and all configuration untouched. The initialization wait does not run again. The next frame edge becomes the new reference.

Top module: `clkmon_sync_watch`

## Requirements
- R1: While `rst_n` is low and in the cycle after its release, `ready_o` and `cnt_rst_o` are 0.
- R2: The expected frame period N in master-clock cycles is set by `ratio_sel`: 2'b00 gives 128, 2'b01 gives 256, 2'b10 gives 384 and 2'b11 gives 512. The select is read live, so the same measured interval can be a slip under one select and not under another.
- R3: After `pwr_dn` goes low, `ready_o` rises one cycle after the master-clock edge at which the 8th bit-clock rising edge is sampled. Bit-clock edges seen while `pwr_dn` is high are not counted.
- R4: While `pwr_dn` is high, `ready_o` and `cnt_rst_o` are 0 from the next cycle onward. All alignment state is dropped, and frame edges cause no pulse.
- R5: Frame rising edges that occur before `ready_o` is high are ignored. The first frame rising edge while ready and not tracking becomes the reference, and it causes no pulse.
- R6: While tracking, a slip is flagged when the count of master-clock edges since the last accepted frame edge reaches N+384. This happens whether or not a frame edge arrives on that edge.
- R7: While tracking, a frame edge that arrives 128 or fewer cycles after the previous accepted edge is a slip. This is possible only when N+1 > 384 + 128 would fail otherwise, that is for N = 512, where it means an interval of N-384 or less.
- R8: An interval whose distance from N is 383 or less causes no pulse, whatever the phase of the frame clock against the master clock.
- R9: `cnt_rst_o` is high for exactly one master-clock cycle per slip, in the cycle after the edge on which the slip is detected.
- R10: A slip leaves `ready_o` high and does not repeat the bit-clock wait. The frame edge that caused the slip is not used as a reference. The next frame rising edge is captured as the new reference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Power-down; high holds the block idle |
| ratio_sel | input | 2 | Master-clock to sample-rate ratio select |
| bclk_in | input | 1 | Bit clock level, synchronous to clk |
| frame_in | input | 1 | Frame clock level, synchronous to clk |
| ready_o | output | 1 | Initialization complete |
| cnt_rst_o | output | 1 | One-cycle reset for frame and bit counters |

## Verification
Every result is due exactly one master-clock cycle after the edge at which its cause is sampled. For `ready_o`, the cause is the 8th bit-clock rise. For `cnt_rst_o`, it is the offending frame rise or the edge on which the count reaches N+384. For both outputs under power-down, it is the first edge with `pwr_dn` high. The bench drives inputs on falling edges. At each rising edge, a behavioural model measures intervals with an absolute cycle stamp, and its expectations are compared with both outputs on the following falling edge, so the one-cycle latency is checked on every clock. Per-section slip counts are also checked against counts worked out from the requirements for each chosen interval, including the boundary intervals 383/384 away from N.

// File: rtl/clkmon_pkg.sv
`timescale 1ns/1ps
package clkmon_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_INIT  = 2'd1,
        ST_SEEK  = 2'd2,
        ST_TRACK = 2'd3
    } mon_state_e;

endpackage

// File: rtl/clkmon_edge.sv
`timescale 1ns/1ps
// Rising-edge detector for a level already synchronous to clk.
module clkmon_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/clkmon_ratio.sv
`timescale 1ns/1ps
// Decodes the ratio select into the expected frame period in clk cycles.
module clkmon_ratio
    import clkmon_pkg::*;
#(
    parameter int BASE  = 128,
    parameter int CNT_W = 10
) (
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] period
);
    always_comb begin
        period = CNT_W'(BASE) * (CNT_W'(sel) + CNT_W'(1));
    end
endmodule

// File: rtl/clkmon_window.sv
`timescale 1ns/1ps
// Tolerance window: late when the running count reaches period+slip,
// early when an edge arrives at or below period-slip.
module clkmon_window #(
    parameter int CNT_W = 10,
    parameter int SLIP  = 384
) (
    input  logic [CNT_W-1:0] elapsed,
    input  logic [CNT_W-1:0] period,
    input  logic             edge_now,
    output logic             late,
    output logic             early
);
    localparam logic [CNT_W-1:0] SLIP_C = CNT_W'(SLIP);

    always_comb begin
        late  = (elapsed >= (period + SLIP_C));
        early = edge_now && (period > SLIP_C) && (elapsed <= (period - SLIP_C));
    end
endmodule

// File: rtl/clkmon_sync_watch.sv
`timescale 1ns/1ps
module clkmon_sync_watch
    import clkmon_pkg::*;
#(
    parameter int BASE       = 128,
    parameter int SLIP_UNITS = 3,
    parameter int INIT_BITS  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_dn,
    input  logic [SEL_W-1:0] ratio_sel,
    input  logic             bclk_in,
    input  logic             frame_in,
    output logic             ready_o,
    output logic             cnt_rst_o
);
    localparam int SLIP   = BASE * SLIP_UNITS;
    localparam int MAX_N  = BASE * (2 ** SEL_W);
    localparam int LIMIT  = MAX_N + SLIP;
    localparam int CNT_W  = $clog2(LIMIT + 1);
    localparam int INIT_W = $clog2(INIT_BITS + 1);
    localparam int N_IN   = 2;

    typedef struct packed {
        mon_state_e        st;
        logic [INIT_W-1:0] nbit;
        logic [CNT_W-1:0]  per;
        logic              ready;
        logic              pulse;
    } mon_t;

    mon_t q, d;

    // index 0: bit clock, index 1: frame clock
    logic [N_IN-1:0] lvl_in;
    logic [N_IN-1:0] rise_in;
    assign lvl_in = {frame_in, bclk_in};

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_edge
        clkmon_edge u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .lvl  (lvl_in[gi]),
            .rise (rise_in[gi])
        );
    end

    logic             bclk_rise;
    logic             frame_rise;
    assign bclk_rise  = rise_in[0];
    assign frame_rise = rise_in[1];

    logic [CNT_W-1:0] exp_period;
    logic             late;
    logic             early;

    clkmon_ratio #(.BASE(BASE), .CNT_W(CNT_W)) u_ratio (
        .sel   (ratio_sel),
        .period(exp_period)
    );

    clkmon_window #(.CNT_W(CNT_W), .SLIP(SLIP)) u_win (
        .elapsed (q.per),
        .period  (exp_period),
        .edge_now(frame_rise),
        .late    (late),
        .early   (early)
    );

    always_comb begin
        d       = q;
        d.pulse = 1'b0;
        if (pwr_dn) begin
            d.st    = ST_OFF;
            d.nbit  = '0;
            d.per   = '0;
            d.ready = 1'b0;
        end else begin
            case (q.st)
                ST_OFF: begin
                    d.st   = ST_INIT;
                    d.nbit = '0;
                end
                ST_INIT: begin
                    if (bclk_rise) begin
                        if (q.nbit == INIT_W'(INIT_BITS - 1)) begin
                            d.st    = ST_SEEK;
                            d.nbit  = '0;
                            d.ready = 1'b1;
                        end else begin
                            d.nbit = q.nbit + INIT_W'(1);
                        end
                    end
                end
                ST_SEEK: begin
                    if (frame_rise) begin
                        d.st  = ST_TRACK;
                        d.per = CNT_W'(1);
                    end
                end
                ST_TRACK: begin
                    if (late || early) begin
                        d.pulse = 1'b1;
                        d.st    = ST_SEEK;
                        d.per   = '0;
                    end else if (frame_rise) begin
                        d.per = CNT_W'(1);
                    end else begin
                        d.per = q.per + CNT_W'(1);
                    end
                end
                default: d.st = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_OFF;
            q.nbit  <= '0;
            q.per   <= '0;
            q.ready <= 1'b0;
            q.pulse <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign ready_o   = q.ready;
    assign cnt_rst_o = q.pulse;
endmodule

// File: rtl/clkmon_sync_watch_chk.sv
`timescale 1ns/1ps
module clkmon_sync_watch_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_dn,
    input logic bclk_in,
    input logic ready_o,
    input logic cnt_rst_o
);
    p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst_o |=> !cnt_rst_o);

    p_slip_keeps_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst_o |-> ready_o);

    p_ready_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !pwr_dn) |=> ready_o);

    p_pdn_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> (!ready_o && !cnt_rst_o));

    p_ready_on_bclk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> ($past(bclk_in) && !$past(pwr_dn)));

    p_no_pulse_unready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |=> !cnt_rst_o);
endmodule

bind clkmon_sync_watch clkmon_sync_watch_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_dn   (pwr_dn),
    .bclk_in  (bclk_in),
    .ready_o  (ready_o),
    .cnt_rst_o(cnt_rst_o)
);

// File: tb/sim_clkmon_sync_watch.sv
`timescale 1ns/1ps
module sim_clkmon_sync_watch;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_dn = 1'b1;
    logic [1:0] ratio_sel = 2'b00;
    logic       bclk_drv = 1'b0;
    logic       frame_drv = 1'b0;
    logic       ready_o;
    logic       cnt_rst_o;

    int    total = 0;
    int    bad = 0;
    int    pulses = 0;
    bit    prev_rst = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    clkmon_sync_watch u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_dn   (pwr_dn),
        .ratio_sel(ratio_sel),
        .bclk_in  (bclk_drv),
        .frame_in (frame_drv),
        .ready_o  (ready_o),
        .cnt_rst_o(cnt_rst_o)
    );

    // Behavioural reference: absolute cycle stamps, interval = now - reference stamp.
    int m_mode = 0;          // 0 off, 1 counting bit clocks, 2 seeking, 3 tracking
    int m_bits = 0;
    int m_now = 0;
    int m_ref = 0;
    bit m_pf = 0, m_pb = 0;
    bit exp_ready = 0, exp_rst = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_bits = 0; m_now = 0; m_ref = 0;
            m_pf = 0; m_pb = 0; exp_ready = 0; exp_rst = 0;
        end else begin
            bit fr, br;
            int gap, nexp;
            fr = frame_drv && !m_pf;
            br = bclk_drv && !m_pb;
            m_pf = frame_drv;
            m_pb = bclk_drv;
            m_now = m_now + 1;
            exp_rst = 0;
            if (pwr_dn) begin
                m_mode = 0; m_bits = 0; exp_ready = 0;
            end else if (m_mode == 0) begin
                m_mode = 1; m_bits = 0;
            end else if (m_mode == 1) begin
                if (br) begin
                    m_bits = m_bits + 1;
                    if (m_bits == 8) begin m_mode = 2; exp_ready = 1; end
                end
            end else if (m_mode == 2) begin
                if (fr) begin m_ref = m_now; m_mode = 3; end
            end else begin
                gap  = m_now - m_ref;
                nexp = 128 * (int'(ratio_sel) + 1);
                if (gap >= nexp + 384 || (fr && gap <= nexp - 384)) begin
                    exp_rst = 1; m_mode = 2;
                end else if (fr) begin
                    m_ref = m_now;
                end
            end
        end
    end

    // Cycle-by-cycle comparison, sampled half a period after the active edge.
    always @(negedge clk) begin
        total++;
        if (ready_o !== exp_ready || cnt_rst_o !== exp_rst) begin
            bad++;
            $display("FAIL %s: ready/cnt_rst actual=%b/%b expected=%b/%b at %0t",
                     cur_req, ready_o, cnt_rst_o, exp_ready, exp_rst, $time);
        end
        if (cnt_rst_o === 1'b1) begin
            pulses++;
            total++;   // R9: a pulse never lasts two cycles
            if (prev_rst) begin
                bad++;
                $display("FAIL R9: cnt_rst actual=1 expected=0 on second cycle at %0t", $time);
            end
        end
        prev_rst = (cnt_rst_o === 1'b1);
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bclk_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            bclk_drv = 1'b1; cyc(2);
            bclk_drv = 1'b0; cyc(2);
        end
    endtask

    task automatic frames(input int per, input int n);
        for (int i = 0; i < n; i++) begin
            frame_drv = 1'b1; cyc(4);
            frame_drv = 1'b0; cyc(per - 4);
        end
    endtask

    task automatic chk(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    initial begin
        int p0;
        cyc(4);
        chk("R1 reset ready", int'(ready_o), 0);
        chk("R1 reset cnt_rst", int'(cnt_rst_o), 0);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 after release", int'(ready_o), 0);

        // R3: bit clocks during power-down are not counted
        cur_req = "R3";
        bclk_pulses(3);
        pwr_dn = 1'b0;
        cyc(3);
        bclk_pulses(7);
        cur_req = "R5";
        p0 = pulses;
        frames(20, 1);
        chk("R5 frame before ready", pulses - p0, 0);
        chk("R3 ready after 7 bit clocks", int'(ready_o), 0);
        cur_req = "R3";
        bclk_pulses(1);
        chk("R3 ready after 8 bit clocks", int'(ready_o), 1);

        // R8: select 00, in-tolerance intervals including 128+383
        cur_req = "R8";
        p0 = pulses;
        frames(128, 5);
        frames(511, 1);
        frames(128, 1);
        chk("R8 no slip within 383", pulses - p0, 0);

        // R6: interval of exactly 128+384
        cur_req = "R6";
        frames(512, 1);
        frames(128, 3);
        chk("R6 slip at N+384", pulses - p0, 1);
        chk("R10 ready kept after slip", int'(ready_o), 1);

        // R6: frame clock stops, timeout
        cyc(600);
        chk("R6 timeout slip", pulses - p0, 2);
        chk("R10 ready kept after timeout", int'(ready_o), 1);

        // R10: re-capture on next edge, no further pulse
        cur_req = "R10";
        frames(128, 4);
        chk("R10 recapture without pulse", pulses - p0, 2);

        // R2: interval 600 is fine for select 01 but a slip for select 00
        cur_req = "R2";
        p0 = pulses;
        ratio_sel = 2'b01;
        frames(256, 3);
        frames(600, 1);
        frames(256, 2);
        chk("R2 select 01 interval 600", pulses - p0, 0);
        ratio_sel = 2'b00;
        frames(128, 2);
        frames(600, 1);
        frames(128, 2);
        chk("R2 select 00 interval 600", pulses - p0, 1);
        ratio_sel = 2'b10;
        frames(384, 3);
        frames(768, 1);
        frames(384, 3);
        chk("R2 select 10 interval 768", pulses - p0, 2);

        // R7: select 11, early intervals 129 (ok) and 128 (slip)
        cur_req = "R7";
        p0 = pulses;
        ratio_sel = 2'b11;
        frames(512, 3);
        frames(129, 1);
        frames(512, 1);
        chk("R7 interval 129 not a slip", pulses - p0, 0);
        frames(128, 1);
        frames(512, 3);
        chk("R7 interval 128 is a slip", pulses - p0, 1);
        chk("R10 ready kept after early slip", int'(ready_o), 1);

        // R4: power-down mid-track
        cur_req = "R4";
        p0 = pulses;
        pwr_dn = 1'b1;
        cyc(1);
        chk("R4 ready cleared", int'(ready_o), 0);
        frames(128, 3);
        bclk_pulses(10);
        cyc(1000);
        chk("R4 no pulses while down", pulses - p0, 0);
        chk("R4 ready stays low", int'(ready_o), 0);

        cur_req = "R3";
        pwr_dn = 1'b0;
        cyc(2);
        bclk_pulses(8);
        chk("R3 ready after re-init", int'(ready_o), 1);
        cur_req = "R5";
        frames(512, 3);
        chk("R5 capture after re-init", pulses - p0, 0);
        cyc(4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule